// File: doc/BRIEF.md
# Sequential Instruction Prefetcher with One-Block Side Buffer

This block sits next to a direct-mapped instruction cache and services its misses. When the cache reports a miss for a block, the block first looks in a one-entry side buffer. If that buffer holds the block, the block copies the stored words into the cache and sends no memory request. Otherwise it fetches the block from the next memory level and passes each word to the cache fill port in the cycle it arrives. In both cases it then requests the sequentially following block from memory in the background. That block is kept in the side buffer and is written into the cache only when a later miss asks for it.

A block is eight 32-bit words (32 bytes) and is addressed by its block number. The memory port carries one request at a time with a valid/ready handshake and returns one word per response beat. A miss waiting at the input always goes ahead of a prefetch that has not yet been sent. A miss for a block whose prefetch is already under way waits for that prefetch to finish and never causes a second request.

Top module: `isb_prefetch`

## Requirements
- R1: While reset is held and right after it, miss_ack, mem_req_valid and fill_valid are all 0.
- R2: If a miss finds no matching full block in the side buffer, exactly one memory request is made for the missed block. Each response word appears on the fill port in the same cycle, with fill_idx counting 0 to 7, and fill_last is high only on word 7.
- R3: After a miss has been serviced and while no miss is waiting, one memory request for block number +1 (modulo 2^AW) is made. Its words go into the side buffer and never reach the fill port.
- R4: A miss that matches the full side-buffer block makes no memory request. Its eight words appear on the fill port on eight consecutive cycles, starting the cycle after acceptance. A prefetch of the following block comes after it.
- R5: A miss for the block whose prefetch is in flight is not accepted until that prefetch completes. It makes no memory request of its own and is then served from the side buffer.
- R6: A miss waiting in an idle cycle is served before a pending unsent prefetch, which is dropped. A miss that does not match the side buffer invalidates it, so a later miss for the old buffered block fetches it from memory.
- R7: Only one memory request is outstanding at a time. A request stays valid with a stable address until the memory accepts it.
- R8: miss_ack is high for exactly one cycle per accepted miss, only when the controller is idle.
- R9: The prefetch address wraps from the all-ones block number to block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Cache reports a miss, held until miss_ack |
| miss_blk | input | AW | Block number of the miss |
| miss_ack | output | 1 | Miss accepted this cycle |
| fill_valid | output | 1 | Fill word for the cache this cycle |
| fill_blk | output | AW | Block number being filled |
| fill_idx | output | log2(WORDS) | Word position within the block |
| fill_data | output | DW | Fill word |
| fill_last | output | 1 | Final word of the fill |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Requested block number |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_data | input | DW | Response word |

## Verification
miss_ack is combinational, so it shows up in the cycle the miss is raised while the controller is idle. A demand fill word shows up in the same cycle as its memory beat. Copy words from the side buffer start one cycle after acceptance and follow on back to back. A prefetch request is raised two cycles after the last fill word (one idle cycle, then the request state). The bench drives at the falling edge and samples one nanosecond later, so it sees each result inside the cycle in which it is due. Counts of memory requests are read only after fill_last or after idle waits of forty cycles, which are longer than any prefetch takes in the fixed-latency phase.

// File: rtl/isb_pkg.sv
`timescale 1ns/100ps
package isb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DDAT,
    ST_PREQ,
    ST_PDAT,
    ST_COPY
  } isb_state_e;
endpackage

// File: rtl/isb_sbuf.sv
`timescale 1ns/100ps
module isb_sbuf #(
  parameter int AW    = 27,
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     alloc,
  input  logic [AW-1:0]            alloc_tag,
  input  logic                     wr_en,
  input  logic                     wr_last,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic                     valid,
  output logic                     full,
  output logic [AW-1:0]            tag,
  output logic [DW-1:0]            rd_data
);
  localparam int IW = $clog2(WORDS);

  logic          valid_q, valid_d;
  logic          full_q, full_d;
  logic [AW-1:0] tag_q;
  logic [DW-1:0] word_q [WORDS];

  always_comb begin
    valid_d = valid_q;
    full_d  = full_q;
    if (alloc) begin
      valid_d = 1'b1;
      full_d  = 1'b0;
    end else if (clear) begin
      valid_d = 1'b0;
      full_d  = 1'b0;
    end else if (wr_last) begin
      full_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      full_q  <= full_d;
      if (alloc) tag_q <= alloc_tag;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) word_q[g] <= wr_data;
    end
  end

  assign valid   = valid_q;
  assign full    = full_q;
  assign tag     = tag_q;
  assign rd_data = word_q[rd_idx];

  AST_WR_INTO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> valid_q && !full_q); // R3
endmodule

// File: rtl/isb_ctrl.sv
`timescale 1ns/100ps
module isb_ctrl
  import isb_pkg::*;
#(
  parameter int AW    = 27,
  parameter int WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  input  logic [AW-1:0]            miss_blk,
  output logic                     miss_ack,
  input  logic                     sb_valid,
  input  logic                     sb_full,
  input  logic [AW-1:0]            sb_tag,
  output logic                     mem_req_valid,
  output logic [AW-1:0]            mem_req_addr,
  input  logic                     mem_req_ready,
  input  logic                     mem_rsp_valid,
  output logic                     sb_clear,
  output logic                     sb_alloc,
  output logic                     sb_wr,
  output logic                     sb_wr_last,
  output logic [$clog2(WORDS)-1:0] beat_idx,
  output logic [AW-1:0]            cur_blk,
  output logic                     demand_beat,
  output logic                     copy_beat
);
  localparam int            IW   = $clog2(WORDS);
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  isb_state_e    state_q, state_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] pf_q, pf_d;
  logic          pend_q, pend_d;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cur_d       = cur_q;
    pf_d        = pf_q;
    pend_d      = pend_q;
    miss_ack    = 1'b0;
    mem_req_valid = 1'b0;
    sb_clear    = 1'b0;
    sb_alloc    = 1'b0;
    sb_wr       = 1'b0;
    sb_wr_last  = 1'b0;
    demand_beat = 1'b0;
    copy_beat   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (miss_valid) begin
          miss_ack = 1'b1;
          cur_d    = miss_blk;
          cnt_d    = '0;
          pend_d   = 1'b0;
          if (sb_valid && sb_full && (sb_tag == miss_blk)) begin
            state_d = ST_COPY;
          end else begin
            sb_clear = 1'b1;
            state_d  = ST_DREQ;
          end
        end else if (pend_q) begin
          state_d = ST_PREQ;
        end
      end
      ST_DREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          cnt_d   = '0;
          state_d = ST_DDAT;
        end
      end
      ST_DDAT: begin
        if (mem_rsp_valid) begin
          demand_beat = 1'b1;
          cnt_d       = cnt_q + IW'(1);
          if (cnt_q == LAST) begin
            pend_d  = 1'b1;
            pf_d    = cur_q + AW'(1);
            state_d = ST_IDLE;
          end
        end
      end
      ST_PREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) begin
          sb_alloc = 1'b1;
          pend_d   = 1'b0;
          cnt_d    = '0;
          state_d  = ST_PDAT;
        end
      end
      ST_PDAT: begin
        if (mem_rsp_valid) begin
          sb_wr = 1'b1;
          cnt_d = cnt_q + IW'(1);
          if (cnt_q == LAST) begin
            sb_wr_last = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_COPY: begin
        copy_beat = 1'b1;
        cnt_d     = cnt_q + IW'(1);
        if (cnt_q == LAST) begin
          sb_clear = 1'b1;
          pend_d   = 1'b1;
          pf_d     = cur_q + AW'(1);
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      pf_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cur_q   <= cur_d;
      pf_q    <= pf_d;
      pend_q  <= pend_d;
    end
  end

  assign mem_req_addr = (state_q == ST_DREQ) ? cur_q : pf_q;
  assign beat_idx     = cnt_q;
  assign cur_blk      = cur_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ack |=> !miss_ack); // R8
  AST_COPY_QUIET_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    copy_beat |-> !mem_req_valid); // R4
endmodule

// File: rtl/isb_prefetch.sv
`timescale 1ns/100ps
module isb_prefetch #(
  parameter int AW    = 27,
  parameter int WORDS = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  input  logic [AW-1:0]            miss_blk,
  output logic                     miss_ack,
  output logic                     fill_valid,
  output logic [AW-1:0]            fill_blk,
  output logic [$clog2(WORDS)-1:0] fill_idx,
  output logic [DW-1:0]            fill_data,
  output logic                     fill_last,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [AW-1:0]            mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data
);
  localparam int IW = $clog2(WORDS);

  logic          sb_valid, sb_full, sb_clear, sb_alloc, sb_wr, sb_wr_last;
  logic [AW-1:0] sb_tag, cur_blk;
  logic [IW-1:0] beat_idx;
  logic [DW-1:0] sb_rd;
  logic          demand_beat, copy_beat;

  isb_ctrl #(.AW(AW), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_ack(miss_ack),
    .sb_valid(sb_valid), .sb_full(sb_full), .sb_tag(sb_tag),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .sb_clear(sb_clear), .sb_alloc(sb_alloc), .sb_wr(sb_wr),
    .sb_wr_last(sb_wr_last), .beat_idx(beat_idx), .cur_blk(cur_blk),
    .demand_beat(demand_beat), .copy_beat(copy_beat)
  );

  isb_sbuf #(.AW(AW), .WORDS(WORDS), .DW(DW)) u_sbuf (
    .clk(clk), .rst_n(rst_n),
    .clear(sb_clear), .alloc(sb_alloc), .alloc_tag(mem_req_addr),
    .wr_en(sb_wr), .wr_last(sb_wr_last), .wr_idx(beat_idx),
    .wr_data(mem_rsp_data), .rd_idx(beat_idx),
    .valid(sb_valid), .full(sb_full), .tag(sb_tag), .rd_data(sb_rd)
  );

  assign fill_valid = demand_beat | copy_beat;
  assign fill_data  = copy_beat ? sb_rd : mem_rsp_data;
  assign fill_idx   = beat_idx;
  assign fill_blk   = cur_blk;
  assign fill_last  = fill_valid && (beat_idx == IW'(WORDS - 1));

  AST_PREFETCH_NOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    sb_wr |-> !fill_valid); // R3
endmodule

// File: tb/isb_prefetch_test.sv
`timescale 1ns/100ps
module isb_prefetch_test;
  localparam int AW = 27;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid;
  logic [AW-1:0] miss_blk;
  logic          miss_ack;
  logic          fill_valid;
  logic [AW-1:0] fill_blk;
  logic [2:0]    fill_idx;
  logic [31:0]   fill_data;
  logic          fill_last;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_data;

  int total = 0;
  int bad   = 0;

  bit            rnd_mode = 1'b0;
  int            req_cnt = 0;
  logic [AW-1:0] last_addr = '0;
  logic [AW-1:0] prev_addr = '0;
  logic [AW-1:0] cur_miss = '0;
  logic [AW-1:0] prev_miss = '0;
  bit            any_miss = 1'b0;

  always #2.5 clk = ~clk;

  isb_prefetch uut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_ack(miss_ack),
    .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_idx(fill_idx),
    .fill_data(fill_data), .fill_last(fill_last),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] word_of(input logic [AW-1:0] b, input int i);
    return ({5'b0, b} * 32'h9E3779B1) ^ (32'(i) << 3) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // next-level memory model
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (rst_n && mem_req_valid) begin
        logic [AW-1:0] a;
        int            dly, lat;
        dly = rnd_mode ? int'($urandom % 3) : 0;
        lat = rnd_mode ? 1 + int'($urandom % 5) : 6;
        repeat (dly) @(negedge clk);
        a = mem_req_addr;
        mem_req_ready = 1'b1;
        req_cnt++;
        prev_addr = last_addr;
        last_addr = a;
        if (rnd_mode && any_miss)
          chk(a == cur_miss || a == cur_miss + AW'(1) || a == prev_miss + AW'(1),
              "R3 request address", 64'(a), 64'(cur_miss));
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = word_of(a, i);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          if (rnd_mode && ($urandom % 2 == 1)) @(negedge clk);
        end
      end
    end
  end

  // mode: 0 demand, 1 copy, 2 either
  task automatic do_miss(input logic [AW-1:0] b, input int mode, output int waited);
    int  idx;
    bit  done;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_blk   = b;
    prev_miss  = cur_miss;
    cur_miss   = b;
    any_miss   = 1'b1;
    waited     = 0;
    #1;
    while (!miss_ack) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    idx  = 0;
    done = 1'b0;
    while (!done) begin
      if (miss_ack) chk(1'b0, "R8 ack while busy", 64'(miss_ack), 64'd0);
      if (fill_valid) begin
        chk(fill_data == word_of(b, idx), mode == 1 ? "R4 copy data" : "R2 fill data",
            64'(fill_data), 64'(word_of(b, idx)));
        chk(fill_idx == 3'(idx) && fill_blk == b, "R2 fill index/block",
            {32'(fill_blk), 32'(fill_idx)}, {32'(b), 32'(idx)});
        chk(fill_last == (idx == 7), "R2 fill_last position", 64'(fill_last), 64'(idx == 7));
        idx++;
        if (idx == 8) done = 1'b1;
      end else if (mode == 1) begin
        chk(1'b0, "R4 copy beats not consecutive", 64'(fill_valid), 64'd1);
      end else if (mem_rsp_valid && mode == 0) begin
        chk(1'b0, "R2 response not passed through", 64'(fill_valid), 64'd1);
      end
      if (!done) begin
        @(negedge clk);
        #1;
      end
    end
  endtask

  task automatic idle_wait(input int n, output int fills);
    fills = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (fill_valid) fills++;
    end
  endtask

  initial begin
    int w, f, r0;
    logic [AW-1:0] a, b;
    miss_valid = 1'b0;
    miss_blk   = '0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!miss_ack && !mem_req_valid && !fill_valid, "R1 outputs in reset",
        {61'd0, miss_ack, mem_req_valid, fill_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!miss_ack && !mem_req_valid && !fill_valid, "R1 outputs after reset",
        {61'd0, miss_ack, mem_req_valid, fill_valid}, 64'd0);

    a = 27'h100;
    // R2: cold miss
    r0 = req_cnt;
    do_miss(a, 0, w);
    chk(req_cnt == r0 + 1 && last_addr == a, "R2 one demand request",
        64'(req_cnt - r0), 64'd1);
    // R3: background prefetch of next block, nothing filled
    idle_wait(40, f);
    chk(req_cnt == r0 + 2 && last_addr == a + 1, "R3 prefetch of next block",
        64'(last_addr), 64'(a + 1));
    chk(f == 0, "R3 prefetch not written to cache", 64'(f), 64'd0);

    // R4: buffer hit
    r0 = req_cnt;
    do_miss(a + 1, 1, w);
    chk(req_cnt == r0, "R4 no request on buffer hit", 64'(req_cnt - r0), 64'd0);
    idle_wait(40, f);
    chk(req_cnt == r0 + 1 && last_addr == a + 2, "R4 chained prefetch",
        64'(last_addr), 64'(a + 2));

    // R5: miss during in-flight prefetch of the same block
    r0 = req_cnt;
    do_miss(a + 2, 1, w);
    idle_wait(2, f);
    do_miss(a + 3, 1, w);
    chk(w > 0, "R5 miss held until prefetch done", 64'(w), 64'd1);
    chk(req_cnt == r0 + 1 && last_addr == a + 3, "R5 no duplicate request",
        64'(req_cnt - r0), 64'd1);

    // R6: unrelated miss invalidates buffer; waiting miss beats prefetch
    idle_wait(40, f);
    b  = 27'h2000;
    r0 = req_cnt;
    do_miss(b, 0, w);
    do_miss(a + 4, 0, w);
    chk(req_cnt == r0 + 2 && prev_addr == b && last_addr == a + 4,
        "R6 demand before prefetch, buffer invalidated",
        {32'(prev_addr), 32'(last_addr)}, {32'(b), 32'(a + 4)});
    idle_wait(40, f);
    chk(last_addr == a + 5, "R6 prefetch after second demand", 64'(last_addr), 64'(a + 5));

    // R9: wrap of block number
    do_miss({AW{1'b1}}, 0, w);
    idle_wait(40, f);
    chk(last_addr == '0, "R9 prefetch wraps to block 0", 64'(last_addr), 64'd0);
    r0 = req_cnt;
    do_miss('0, 1, w);
    chk(req_cnt == r0, "R9 wrapped block served from buffer", 64'(req_cnt - r0), 64'd0);

    // random phase
    void'($urandom(32'd4711));
    rnd_mode = 1'b1;
    b = 27'h40;
    for (int k = 0; k < 150; k++) begin
      int gap;
      if ($urandom % 10 < 6) b = b + AW'(1);
      else b = AW'(27'h40 + ($urandom % 64));
      if ($urandom % 20 == 0) b = {AW{1'b1}};
      gap = int'($urandom % 4 == 0 ? 0 : $urandom % 25);
      idle_wait(gap, f);
      chk(f == 0, "R3 no fill while idle", 64'(f), 64'd0);
      do_miss(b, 2, w);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule